// File: doc/BRIEF.md
# Linked-List Descriptor DMA Mover

This block is a bus-master data mover driven by a chain of descriptors held in ordinary memory. Each descriptor is four 32-bit words: a control word, a word whose low twelve bits give the buffer length in bytes, the buffer's start address, and a link word pointing at the following descriptor. A kick pulse starts a walk at the programmed list base. For every descriptor the engine reads the four words in order and checks that the descriptor has been handed to it. It then moves the buffer one 32-bit word at a time, either from memory into the local data FIFO or from the FIFO into memory. Finally it writes the control word back with the ownership bit cleared, and goes on to the next descriptor.

The walk ends after the descriptor flagged as last. At that point a transmit-done or receive-done flag is raised together with a summary flag, unless that descriptor asks for its completion interrupt to be held back. A descriptor that is still owned by software stops the walk and raises an unavailable flag. The next kick then retries that same descriptor. Status flags are cleared by writing 1 to them. A synchronous engine reset input and an engine enable input stop the walk at once.

Top module: `dde_engine`

## Requirements
- R1: After `rst_n` is released, and in the cycle after `soft_rst` is high, `mem_req` is low and every status flag and `irq` are 0.
- R2: When `dma_en` is high, a one-cycle `poll` from idle reads the descriptor words at `base_addr`, `+4`, `+8` and `+12`, in that order, as the first four memory transactions.
- R3: While `dma_en` is low, `poll` starts nothing and `mem_req` stays low.
- R4: A fetched descriptor whose control bit 31 (owned by engine) is 0 moves no data and is not written back. It sets `sts_unavail` and leaves the engine waiting. The next `poll` re-reads that same descriptor address.
- R5: With `dir_rx`=0, the engine reads ceil(L/4) words starting at the buffer address, where L is bits 11:0 of word 1 (bits 31:12 are ignored). It offers them on `fifo_wdata` in address order, and each word is held until `fifo_wready` accepts it. L=0 moves no data.
- R6: With `dir_rx`=1, ceil(L/4) words accepted from the FIFO are written to consecutive buffer addresses. The word after the buffer is left untouched.
- R7: After the last data word of a descriptor, the engine writes its control word back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R8: The next descriptor address is taken from word 3 when control bit 4 (chained) is 1. Otherwise it is `base_addr` when bit 5 (end of ring) is 1. Otherwise it is the current address + 16. Word 3 is ignored when bit 4 is 0.
- R9: When the write-back of a descriptor with control bit 2 (last) completes, the walk ends with no further memory request. If bit 1 (hold interrupt) is 0, it also sets `sts_tx_done` (transmit) or `sts_rx_done` (receive) together with `sts_norm`. If bit 1 is 1, no flag is set.
- R10: Status flags stay set until cleared. The clear bits are `clr[0]` for tx done, `clr[1]` for rx done, `clr[2]` for summary and `clr[3]` for unavailable. A clear affects only its own flag.
- R11: `irq` is high exactly when `sts_norm` or `sts_unavail` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous engine and status reset |
| dma_en | input | 1 | Engine enable; low aborts to idle |
| poll | input | 1 | Kick pulse that starts or resumes the walk |
| dir_rx | input | 1 | 1: FIFO to memory, 0: memory to FIFO (sampled at start) |
| base_addr | input | 32 | Byte address of the first descriptor |
| clr | input | 4 | Write-1-to-clear pulses for the status flags |
| sts_tx_done | output | 1 | Transmit completion flag |
| sts_rx_done | output | 1 | Receive completion flag |
| sts_norm | output | 1 | Summary of completion flags |
| sts_unavail | output | 1 | Descriptor not owned by engine |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| fifo_wvalid | output | 1 | Word offered to the FIFO |
| fifo_wdata | output | 32 | Word for the FIFO |
| fifo_wready | input | 1 | FIFO accepts the offered word |
| fifo_rvalid | input | 1 | FIFO has a word for the engine |
| fifo_rdata | input | 32 | Word from the FIFO |
| fifo_rready | output | 1 | Engine takes the FIFO word |

## Verification
A memory request is seen by the bench on the cycle its address appears. The request completes at the first clock edge at which the bench's acknowledge is high. The bench logs the address and applies a write in that same half-cycle, so fetch order and write-back contents are checked against a log rather than at fixed cycle offsets.

The FIFO words are captured at the falling edge preceding the accepting rising edge, when valid and ready are both known. Status flags rise one edge after the write-back acknowledge and fall one edge after a clear. Each status check therefore waits until the interface has been quiet for 40 cycles, and then samples on a falling edge.

// File: rtl/dde_pkg.sv
package dde_pkg;
  // control word bit positions (the descriptor layout is fixed by software)
  localparam int OWN_B = 31;
  localparam int EOR_B = 5;
  localparam int CH_B  = 4;
  localparam int LS_B  = 2;
  localparam int DIC_B = 1;

  // status vector bit positions
  localparam int ST_TX  = 0;
  localparam int ST_RX  = 1;
  localparam int ST_SUM = 2;
  localparam int ST_UNA = 3;
  localparam int ST_N   = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_TRD, S_TPUSH, S_RPOP, S_RWR, S_WB, S_SUSP
  } dde_state_e;
endpackage

// File: rtl/dde_status.sv
module dde_status
  import dde_pkg::*;
#(
  parameter int N = ST_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (soft_rst) flag_q <= 1'b0;
      else               flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
    end
    assign sts_o[i] = flag_q;
  end
endmodule

// File: rtl/dde_seq.sv
module dde_seq
  import dde_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 12,
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              dma_en,
  input  logic              poll,
  input  logic              dir_rx,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fifo_wvalid,
  output logic [31:0]       fifo_wdata,
  input  logic              fifo_wready,
  input  logic              fifo_rvalid,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_rready,
  output logic              ev_unavail,
  output logic              ev_done_tx,
  output logic              ev_done_rx
);
  localparam int IDX_W  = $clog2(DESC_WORDS);
  localparam int BEAT_W = SIZE_W;
  localparam int STRIDE = DESC_WORDS * 4;

  function automatic logic [BEAT_W-1:0] beats_of(input logic [SIZE_W-1:0] nbytes);
    logic [BEAT_W:0] t;
    t = {1'b0, nbytes} + (BEAT_W+1)'(3);
    return BEAT_W'(t >> 2);
  endfunction

  function automatic logic [ADDR_W-1:0] next_of(input logic [31:0] ctrl,
      input logic [ADDR_W-1:0] cur, input logic [ADDR_W-1:0] link,
      input logic [ADDR_W-1:0] base);
    if (ctrl[CH_B])       return link;
    else if (ctrl[EOR_B]) return base;
    else                  return cur + ADDR_W'(STRIDE);
  endfunction

  dde_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] cur_q, buf_q, link_q, ptr_q;
  logic [31:0]       ctrl_q, hold_q;
  logic [SIZE_W-1:0] size_q;
  logic [BEAT_W-1:0] left_q;
  logic              rx_q;
  logic              go, wb_fin;
  logic [31:0]       wb_word;

  assign go      = dma_en && !soft_rst;
  assign wb_word = ctrl_q & ~(32'h1 << OWN_B);
  assign wb_fin  = go && (state_q == S_WB) && mem_ack;

  assign ev_unavail = go && (state_q == S_CHECK) && !ctrl_q[OWN_B];
  assign ev_done_tx = wb_fin && ctrl_q[LS_B] && !ctrl_q[DIC_B] && !rx_q;
  assign ev_done_rx = wb_fin && ctrl_q[LS_B] && !ctrl_q[DIC_B] &&  rx_q;

  always_comb begin
    mem_req   = (state_q inside {S_FETCH, S_TRD, S_RWR, S_WB});
    mem_we    = (state_q inside {S_RWR, S_WB});
    mem_wdata = (state_q == S_WB) ? wb_word : hold_q;
    unique case (state_q)
      S_FETCH: mem_addr = cur_q + ADDR_W'({idx_q, 2'b00});
      S_TRD,
      S_RWR:   mem_addr = ptr_q;
      default: mem_addr = cur_q;
    endcase
    fifo_wvalid = (state_q == S_TPUSH);
    fifo_wdata  = hold_q;
    fifo_rready = (state_q == S_RPOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; idx_q <= '0; cur_q <= '0; buf_q <= '0; link_q <= '0;
      ptr_q <= '0; ctrl_q <= '0; hold_q <= '0; size_q <= '0; left_q <= '0; rx_q <= 1'b0;
    end else if (!go) begin
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (poll) begin
          cur_q <= base_addr; idx_q <= '0; rx_q <= dir_rx; state_q <= S_FETCH;
        end
        S_SUSP: if (poll) begin
          idx_q <= '0; state_q <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (idx_q)
            IDX_W'(0): ctrl_q <= mem_rdata;
            IDX_W'(1): size_q <= mem_rdata[SIZE_W-1:0];
            IDX_W'(2): buf_q  <= mem_rdata[ADDR_W-1:0];
            default:   link_q <= mem_rdata[ADDR_W-1:0];
          endcase
          if (idx_q == IDX_W'(DESC_WORDS-1)) state_q <= S_CHECK;
          else                               idx_q   <= idx_q + 1'b1;
        end
        S_CHECK: begin
          ptr_q  <= buf_q;
          left_q <= beats_of(size_q);
          if (!ctrl_q[OWN_B])                 state_q <= S_SUSP;
          else if (beats_of(size_q) == '0)    state_q <= S_WB;
          else                                state_q <= rx_q ? S_RPOP : S_TRD;
        end
        S_TRD: if (mem_ack) begin
          hold_q <= mem_rdata; state_q <= S_TPUSH;
        end
        S_TPUSH: if (fifo_wready) begin
          ptr_q  <= ptr_q + ADDR_W'(4);
          left_q <= left_q - 1'b1;
          state_q <= (left_q == BEAT_W'(1)) ? S_WB : S_TRD;
        end
        S_RPOP: if (fifo_rvalid) begin
          hold_q <= fifo_rdata; state_q <= S_RWR;
        end
        S_RWR: if (mem_ack) begin
          ptr_q  <= ptr_q + ADDR_W'(4);
          left_q <= left_q - 1'b1;
          state_q <= (left_q == BEAT_W'(1)) ? S_WB : S_RPOP;
        end
        S_WB: if (mem_ack) begin
          if (ctrl_q[LS_B]) state_q <= S_IDLE;
          else begin
            cur_q   <= next_of(ctrl_q, cur_q, link_q, base_addr);
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dde_engine.sv
module dde_engine
  import dde_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 12,
  parameter int DESC_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              dma_en,
  input  logic              poll,
  input  logic              dir_rx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ST_N-1:0]   clr,
  output logic              sts_tx_done,
  output logic              sts_rx_done,
  output logic              sts_norm,
  output logic              sts_unavail,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fifo_wvalid,
  output logic [31:0]       fifo_wdata,
  input  logic              fifo_wready,
  input  logic              fifo_rvalid,
  input  logic [31:0]       fifo_rdata,
  output logic              fifo_rready
);
  logic            ev_unavail, ev_done_tx, ev_done_rx;
  logic [ST_N-1:0] set_vec, sts_vec;

  dde_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DESC_WORDS(DESC_WORDS)) u_seq (
    .clk, .rst_n, .soft_rst, .dma_en, .poll, .dir_rx, .base_addr,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .fifo_wvalid, .fifo_wdata, .fifo_wready, .fifo_rvalid, .fifo_rdata, .fifo_rready,
    .ev_unavail, .ev_done_tx, .ev_done_rx
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_TX]  = ev_done_tx;
    set_vec[ST_RX]  = ev_done_rx;
    set_vec[ST_SUM] = ev_done_tx | ev_done_rx;
    set_vec[ST_UNA] = ev_unavail;
  end

  dde_status #(.N(ST_N)) u_sts (
    .clk, .rst_n, .soft_rst, .set_i(set_vec), .clr_i(clr), .sts_o(sts_vec)
  );

  assign sts_tx_done = sts_vec[ST_TX];
  assign sts_rx_done = sts_vec[ST_RX];
  assign sts_norm    = sts_vec[ST_SUM];
  assign sts_unavail = sts_vec[ST_UNA];
  assign irq         = sts_vec[ST_SUM] | sts_vec[ST_UNA];
endmodule

// File: rtl/dde_engine_chk.sv
module dde_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              dma_en,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              fifo_wvalid,
  input logic [31:0]       fifo_wdata,
  input logic              fifo_wready,
  input logic              ev_unavail,
  input logic              ev_done_tx,
  input logic              ev_done_rx,
  input logic              sts_tx_done,
  input logic              sts_rx_done,
  input logic              sts_norm,
  input logic              sts_unavail,
  input logic              clr_tx
);
  // R1
  sreset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !mem_req && !sts_norm && !sts_unavail && !sts_tx_done && !sts_rx_done);
  // R3
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !mem_req);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && dma_en && !soft_rst |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R5
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wvalid && !fifo_wready && dma_en && !soft_rst |=> fifo_wvalid && $stable(fifo_wdata));
  // R4
  unavail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |=> sts_unavail);
  // R9
  tx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_tx |=> sts_tx_done && sts_norm);
  // R9
  rx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_rx |=> sts_rx_done && sts_norm);
  // R10
  w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_tx_done && !clr_tx && !soft_rst |=> sts_tx_done);
endmodule

bind dde_engine dde_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dma_en(dma_en),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .fifo_wvalid(fifo_wvalid), .fifo_wdata(fifo_wdata),
  .fifo_wready(fifo_wready), .ev_unavail(ev_unavail), .ev_done_tx(ev_done_tx),
  .ev_done_rx(ev_done_rx), .sts_tx_done(sts_tx_done), .sts_rx_done(sts_rx_done),
  .sts_norm(sts_norm), .sts_unavail(sts_unavail), .clr_tx(clr[0])
);

// File: tb/sim_dde_engine.sv
`timescale 1ns/1ps
module sim_dde_engine;
  localparam logic [31:0] OWN = 32'h8000_0000, CES = 32'h4000_0000, EOR = 32'h20,
                          CH = 32'h10, FS = 32'h8, LS = 32'h4, DIC = 32'h2;

  logic clk = 0, rst_n = 0, soft_rst = 0, dma_en = 0, poll = 0, dir_rx = 0;
  logic [31:0] base_addr = 0;
  logic [3:0]  clr = 0;
  logic sts_tx_done, sts_rx_done, sts_norm, sts_unavail, irq;
  logic mem_req, mem_we, fifo_wvalid, fifo_rready;
  logic [31:0] mem_addr, mem_wdata, fifo_wdata;
  logic mem_ack = 0, fifo_wready = 0, fifo_rvalid = 0;
  logic [31:0] mem_rdata = 0, fifo_rdata = 0;

  dde_engine u0 (.*);

  initial forever #2.5 clk = ~clk;

  logic [31:0] mem [0:255];
  logic [31:0] txn_a [0:1023];
  logic [31:0] sink [0:255];
  logic [31:0] src [0:255];
  int txn_n = 0, sink_n = 0, src_n = 0, src_i = 0, dly = 0;
  bit src_hs = 0;
  int vec = 0, bad = 0;

  // descriptor set-up
  logic [31:0] dad [3], ctl [3], w1 [3], bufa [3];
  int          szb [3];

  function automatic int beats(input logic [31:0] word1);
    int n;
    n = int'(word1 & 32'hFFF);
    return (n / 4) + ((n % 4) != 0 ? 1 : 0);
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] c, input logic [31:0] cur,
                                      input logic [31:0] link, input logic [31:0] base);
    if ((c & CH) != 0)  return link;
    if ((c & EOR) != 0) return base;
    return cur + 32'd16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: acknowledge after 0..2 waits; log every transaction
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (dly == 0) begin
        mem_ack = 1;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[9:2]];
        if (txn_n < 1024) txn_a[txn_n] = mem_addr;
        txn_n++;
        dly = $urandom_range(0, 2);
      end else dly--;
    end
  end

  // FIFO sink (transmit direction)
  initial forever begin
    @(negedge clk);
    fifo_wready = ($urandom_range(0, 3) != 0);
    if (fifo_wvalid && fifo_wready) begin
      if (sink_n < 256) sink[sink_n] = fifo_wdata;
      sink_n++;
    end
  end

  // FIFO source (receive direction)
  initial forever begin
    @(negedge clk);
    if (src_hs) src_i++;
    fifo_rvalid = (src_i < src_n) && ($urandom_range(0, 3) != 0);
    fifo_rdata  = (src_i < 256) ? src[src_i] : 32'h0;
    src_hs = fifo_rvalid && fifo_rready;
  end

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(negedge clk); cyc++; end
    bad++;
    $display("FAIL watchdog actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  task automatic kick();
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (mem_req || fifo_wvalid || fifo_rready) q = 0; else q++;
    end
  endtask

  task automatic clear_logs();
    txn_n = 0; sink_n = 0; src_i = 0; src_n = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 4'hF;
    @(negedge clk); clr = 4'h0;
  endtask

  // n descriptors: D0 chained to D1, D1 falls through (+16) to D2
  task automatic build(input int n, input bit dic);
    dad[0] = 32'h40; dad[1] = 32'hA0; dad[2] = 32'hB0;
    for (int i = 0; i < 3; i++) begin
      bufa[i] = 32'h200 + i * 32'h80;
      ctl[i]  = OWN | ($urandom_range(0, 1) != 0 ? CES : 32'h0);
      if (i == 0) ctl[i] = ctl[i] | FS | CH;
      if (i == n - 1) ctl[i] = (ctl[i] | LS | (dic ? DIC : 32'h0)) & ~CH;
      w1[i] = {$urandom_range(0, 32'hFFFFF), 12'h0} | 32'(szb[i]);
      mem[dad[i][9:2]]       = ctl[i];
      mem[dad[i][9:2] + 1]   = w1[i];
      mem[dad[i][9:2] + 2]   = bufa[i];
      mem[dad[i][9:2] + 3]   = (i == 0) ? dad[1] : $urandom_range(0, 32'h3FC) & 32'h3F0;
      for (int w = 0; w < 8; w++) mem[bufa[i][9:2] + w] = 32'hC0DE_0000 + w + i * 16;
    end
  endtask

  task automatic run_chain(input int n, input bit dic, input bit rx);
    logic [31:0] exp_stream [0:63];
    int tot = 0;
    build(n, dic);
    for (int i = 0; i < n; i++)
      for (int w = 0; w < beats(w1[i]); w++) begin
        exp_stream[tot] = rx ? $urandom : mem[bufa[i][9:2] + w];
        tot++;
      end
    clear_logs();
    if (rx) begin
      for (int k = 0; k < tot; k++) src[k] = exp_stream[k];
      src_n = tot;
    end
    dir_rx = rx; base_addr = dad[0];
    kick();
    wait_quiet();
    // R2 fetch order of the first descriptor
    for (int k = 0; k < 4; k++) chk("R2 fetch order", txn_a[k], dad[0] + 32'(4 * k));
    if (!rx) begin
      chk("R5 word count", 32'(sink_n), 32'(tot));
      for (int k = 0; k < tot; k++) chk("R5 fifo data", sink[k], exp_stream[k]);
    end else begin
      int k = 0;
      for (int i = 0; i < n; i++) begin
        for (int w = 0; w < beats(w1[i]); w++) begin
          chk("R6 buffer data", mem[bufa[i][9:2] + w], exp_stream[k]); k++;
        end
        chk("R6 word after buffer", mem[bufa[i][9:2] + beats(w1[i])],
            32'hC0DE_0000 + beats(w1[i]) + i * 16);
      end
    end
    for (int i = 0; i < n; i++) chk("R7 write-back", mem[dad[i][9:2]], ctl[i] & ~OWN);
    chk("R8 transaction count", 32'(txn_n), 32'(5 * n + tot));
    chk("R9 tx done", 32'(sts_tx_done), 32'(!rx && !dic));
    chk("R9 rx done", 32'(sts_rx_done), 32'(rx && !dic));
    chk("R9 summary", 32'(sts_norm), 32'(!dic));
    chk("R11 irq", 32'(irq), 32'(!dic));
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 fifo idle", {30'h0, fifo_wvalid, fifo_rready}, 0);
    chk("R1 status", {27'h0, irq, sts_unavail, sts_norm, sts_rx_done, sts_tx_done}, 0);

    // R3 poll ignored while disabled
    szb[0] = 8; szb[1] = 4; szb[2] = 4;
    build(3, 0);
    clear_logs(); base_addr = dad[0];
    kick();
    repeat (30) @(negedge clk);
    chk("R3 no request when disabled", 32'(txn_n), 0);
    chk("R3 no status", 32'(irq), 0);
    dma_en = 1;
    @(negedge clk);

    // directed transmit chain, with a zero-length middle buffer
    szb[0] = 5; szb[1] = 0; szb[2] = 12;
    run_chain(3, 0, 0);
    // R10 partial clear
    @(negedge clk); clr = 4'b0001; @(negedge clk); clr = 0;
    @(negedge clk);
    chk("R10 tx cleared", 32'(sts_tx_done), 0);
    chk("R10 summary kept", 32'(sts_norm), 1);
    // R1 engine reset clears status
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    @(negedge clk);
    chk("R1 soft reset status", {27'h0, irq, sts_unavail, sts_norm, sts_rx_done, sts_tx_done}, 0);

    // directed receive chain
    szb[0] = 16; szb[1] = 7; szb[2] = 1;
    run_chain(3, 0, 1);
    clear_all();
    // held interrupt on last descriptor
    szb[0] = 4; szb[1] = 9;
    run_chain(2, 1, 0);

    // R4 descriptor not owned, then resume at the same address
    build(2, 0);
    mem[dad[1][9:2]] = LS;
    mem[dad[0][9:2] + 1] = 32'd4;
    clear_logs(); dir_rx = 0; base_addr = dad[0];
    kick(); wait_quiet();
    chk("R4 unavailable flag", 32'(sts_unavail), 1);
    chk("R11 irq on unavailable", 32'(irq), 1);
    chk("R4 no data for unowned", 32'(sink_n), 1);
    chk("R4 no write-back of unowned", mem[dad[1][9:2]], LS);
    chk("R9 no done", 32'(sts_tx_done), 0);
    clear_all();
    @(negedge clk);
    chk("R10 unavailable cleared", 32'(sts_unavail), 0);
    mem[dad[1][9:2]] = OWN | LS;
    clear_logs();
    kick(); wait_quiet();
    chk("R4 resume address", txn_a[0], dad[1]);
    chk("R4 done after resume", 32'(sts_tx_done), 1);
    clear_all();

    // R8 end-of-ring returns to the base (now handed back, so unavailable)
    build(2, 0);
    mem[dad[0][9:2] + 1] = 32'd8;
    mem[dad[1][9:2]] = OWN | EOR;
    mem[dad[1][9:2] + 1] = 32'd4;
    clear_logs(); base_addr = dad[0];
    kick(); wait_quiet();
    chk("R8 ring wrap count", 32'(txn_n), 32'd17);
    for (int k = 0; k < 4; k++) chk("R8 ring wrap address", txn_a[13 + k], dad[0] + 32'(4 * k));
    chk("R8 wrap hits unowned", 32'(sts_unavail), 1);
    chk("R8 no done", 32'(sts_tx_done), 0);
    clear_all();
    // next-pointer restated by bench function
    chk("R8 next rule chained", nxt(CH | EOR, 32'h40, 32'h100, 32'h10), 32'h100);
    soft_rst = 1; @(negedge clk); soft_rst = 0;

    // randomized chains
    for (int it = 0; it < 8; it++) begin
      int n = $urandom_range(1, 3);
      for (int i = 0; i < 3; i++) szb[i] = $urandom_range(0, 24);
      run_chain(n, $urandom_range(0, 3) == 0, $urandom_range(0, 1) != 0);
      clear_all();
      @(negedge clk);
      chk("R10 all cleared", {28'h0, sts_unavail, sts_norm, sts_rx_done, sts_tx_done}, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule